// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Controller

This block moves a block of words between a peripheral and system memory over the same shared bus that the processor and memory use. The processor programs four things through a small register write port: the direction of the move, the bus address of the peripheral, the first memory address and the number of words. It then writes a start command and returns to its own work. The controller moves the block one word at a time. For each word it requests the bus, waits for the grant and spends two bus cycles: one to read the source and one to write the destination. It then drops its request so that the processor gets the bus back between words.

The peripheral address stays fixed for the whole block. The memory address steps up by one after each word and the remaining count steps down by one. When the count reaches zero, a done flag is set and drives the interrupt line. The flag stays set until the processor clears it. A start with a count of zero finishes at once and uses no bus cycles. While a block is in progress, every register write, including a new start, is dropped.

The sequencer has five states. IDLE waits for an accepted start: a zero count sets done and stays in IDLE, and any other count goes to REQUEST. REQUEST holds the bus request and goes to FIRST once the grant is seen. FIRST reads the source word into a latch under the grant and goes to SECOND. SECOND writes the latched word to the destination under the grant, steps the counters and goes to RELEASE. RELEASE drops the request for one cycle, then goes back to REQUEST if words remain, or sets done and goes to IDLE.

Top module: `csdma_ctrl`

## Requirements
- R1: After reset the controller is idle. The status register (select 4) reads 0, with busy in bit 0 and done in bit 1. irq, bus_req, bus_rd and bus_wr are all 0.
- R2: bus_rd and bus_wr are each asserted only in a cycle where both bus_req and bus_grant are high, and never both in the same cycle.
- R3: Each word takes exactly one read cycle followed directly by one write cycle. With direction bit 0 of the control register (select 0) set to 1, the read is at the peripheral address and the write goes to memory. With direction 0, the read is at memory and the write goes to the peripheral. The write data equals the word returned in the read cycle.
- R4: The peripheral address (select 1) stays constant. The memory address (select 2) rises by one after each word, and the count (select 3) falls by one. Both read back their current values.
- R5: After the write cycle of every word, bus_req is low for at least the next cycle.
- R6: While bus_grant stays low, the controller keeps bus_req high and makes no bus read or write.
- R7: When the count reaches zero, done and irq go high. They stay high until a write to the status register with bit 1 set, or a new start, clears them.
- R8: A start (bit 1 of a control-register write) with a count of 0 sets done and irq on the same clock edge and makes no bus cycle.
- R9: While busy, writes to the address and count registers are ignored.
- R10: While busy, a start command is ignored, and the direction of the block in progress does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 peripheral address, 2 memory address, 3 count, 4 status |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Read-back of the selected register |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| irq | output | 1 | Block-complete interrupt |

## Verification
The assertions check the bus rules on every cycle: strobes only under request and grant, a write always directly after a read and carrying the word just read, the request dropped after each write, and irq holding until a register write. The bench scenarios show what only a whole block can: the final memory and peripheral contents in both directions, the address and count read-back, the stall while the grant is withheld, and the zero-count start. They also show that writes and a second start made in mid-transfer leave the programmed values untouched.

// File: rtl/csdma_pkg.sv
package csdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_FIRST,
        ST_SECOND,
        ST_RELEASE
    } csdma_state_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DEV    = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MEM    = 3'd2;
    localparam logic [SEL_W-1:0] SEL_COUNT  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd4;

    localparam int CTRL_DIR_BIT   = 0;
    localparam int CTRL_START_BIT = 1;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_DONE_BIT  = 1;

endpackage

// File: rtl/csdma_regs.sv
module csdma_regs
    import csdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             busy,
    input  logic             step,
    input  logic             set_done,
    output logic             start_go,
    output logic             dir,
    output logic [AW-1:0]    dev_addr,
    output logic [AW-1:0]    mem_addr,
    output logic             count_zero,
    output logic             done
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [AW-1:0] ADR_ONE = AW'(1);

    logic          dir_q;
    logic [AW-1:0] dev_q;
    logic [AW-1:0] mem_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          wr_ok;
    logic          clr_done;

    assign wr_ok    = cfg_we && !busy;
    assign start_go = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_START_BIT];
    assign clr_done = wr_ok && (cfg_sel == SEL_STATUS) && cfg_wdata[STAT_DONE_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            dev_q <= '0;
        end else if (wr_ok) begin
            if (cfg_sel == SEL_CTRL) dir_q <= cfg_wdata[CTRL_DIR_BIT];
            if (cfg_sel == SEL_DEV)  dev_q <= AW'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            mem_q <= mem_q + ADR_ONE;
            cnt_q <= cnt_q - CNT_ONE;
        end else if (wr_ok) begin
            if (cfg_sel == SEL_MEM)   mem_q <= AW'(cfg_wdata);
            if (cfg_sel == SEL_COUNT) cnt_q <= CW'(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (set_done) done_q <= 1'b1;
        else if (start_go || clr_done) done_q <= 1'b0;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_sel)
            SEL_CTRL:   cfg_rdata[CTRL_DIR_BIT] = dir_q;
            SEL_DEV:    cfg_rdata = DW'(dev_q);
            SEL_MEM:    cfg_rdata = DW'(mem_q);
            SEL_COUNT:  cfg_rdata = DW'(cnt_q);
            SEL_STATUS: begin
                cfg_rdata[STAT_BUSY_BIT] = busy;
                cfg_rdata[STAT_DONE_BIT] = done_q;
            end
            default:    cfg_rdata = '0;
        endcase
    end

    assign dir        = dir_q;
    assign dev_addr   = dev_q;
    assign mem_addr   = mem_q;
    assign count_zero = (cnt_q == '0);
    assign done       = done_q;

endmodule

// File: rtl/csdma_fsm.sv
module csdma_fsm
    import csdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_go,
    input  logic count_zero,
    input  logic bus_grant,
    output logic busy,
    output logic bus_req,
    output logic rd_stb,
    output logic wr_stb,
    output logic second,
    output logic capture,
    output logic step,
    output logic set_done
);

    csdma_state_e state_q;
    csdma_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        busy     = 1'b1;
        bus_req  = 1'b0;
        rd_stb   = 1'b0;
        wr_stb   = 1'b0;
        second   = 1'b0;
        capture  = 1'b0;
        step     = 1'b0;
        set_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (start_go) begin
                    if (count_zero) set_done = 1'b1;
                    else            state_d  = ST_REQUEST;
                end
            end
            ST_REQUEST: begin
                bus_req = 1'b1;
                if (bus_grant) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                bus_req = 1'b1;
                rd_stb  = bus_grant;
                capture = bus_grant;
                if (bus_grant) state_d = ST_SECOND;
            end
            ST_SECOND: begin
                bus_req = 1'b1;
                second  = 1'b1;
                wr_stb  = bus_grant;
                step    = bus_grant;
                if (bus_grant) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (count_zero) begin
                    set_done = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    state_d  = ST_REQUEST;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/csdma_busmux.sv
module csdma_busmux #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir,
    input  logic          second,
    input  logic          capture,
    input  logic [AW-1:0] dev_addr,
    input  logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata
);

    logic [DW-1:0] hold_q;
    logic          use_dev;

    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (capture) hold_q <= bus_rdata;
    end

    // dir=1: peripheral is the source (first cycle), memory the sink
    assign use_dev   = dir ^ second;
    assign bus_addr  = use_dev ? dev_addr : mem_addr;
    assign bus_wdata = hold_q;

endmodule

// File: rtl/csdma_ctrl.sv
module csdma_ctrl
    import csdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output logic             bus_req,
    input  logic             bus_grant,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             irq
);

    logic          busy;
    logic          step;
    logic          set_done;
    logic          start_go;
    logic          dir;
    logic [AW-1:0] dev_addr;
    logic [AW-1:0] mem_addr;
    logic          count_zero;
    logic          second;
    logic          capture;

    csdma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .busy       (busy),
        .step       (step),
        .set_done   (set_done),
        .start_go   (start_go),
        .dir        (dir),
        .dev_addr   (dev_addr),
        .mem_addr   (mem_addr),
        .count_zero (count_zero),
        .done       (irq)
    );

    csdma_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_go   (start_go),
        .count_zero (count_zero),
        .bus_grant  (bus_grant),
        .busy       (busy),
        .bus_req    (bus_req),
        .rd_stb     (bus_rd),
        .wr_stb     (bus_wr),
        .second     (second),
        .capture    (capture),
        .step       (step),
        .set_done   (set_done)
    );

    csdma_busmux #(.AW(AW), .DW(DW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir       (dir),
        .second    (second),
        .capture   (capture),
        .dev_addr  (dev_addr),
        .mem_addr  (mem_addr),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: rtl/csdma_chk.sv
module csdma_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          bus_req,
    input logic          bus_grant,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          irq
);

    AST_STROBE_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_req && bus_grant)); // R2

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R2

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr); // R3

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd)); // R3

    AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_wdata == $past(bus_rdata))); // R3

    AST_RELEASE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_req); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cfg_we) |=> irq); // R7

endmodule

bind csdma_ctrl csdma_chk #(.DW(DW)) u_chk (.*);

// File: tb/csdma_ctrl_bench.sv
module csdma_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          bus_req;
    logic          bus_grant;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_rd;
    logic          bus_wr;
    logic          irq;

    logic          cpu_hold = 1'b0;
    logic [DW-1:0] dev_base = 16'hA000;

    int n_checks = 0;
    int n_fail   = 0;

    // bench-side bus: addresses with bit 15 set belong to the peripheral
    logic [DW-1:0] mem [256];
    logic [DW-1:0] dev_log [64];
    int rd_n = 0;
    int wr_n = 0;
    int dev_rd_n = 0;
    int log_n = 0;
    int rel_bad = 0;
    logic prev_wr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_grant = bus_req && !cpu_hold;
    assign bus_rdata = bus_addr[15] ? (dev_base + DW'(dev_rd_n)) : mem[bus_addr[7:0]];

    always @(posedge clk) begin
        if (prev_wr && bus_req) rel_bad <= rel_bad + 1;
        prev_wr <= bus_wr;
        if (bus_rd) begin
            rd_n <= rd_n + 1;
            if (bus_addr[15]) dev_rd_n <= dev_rd_n + 1;
        end
        if (bus_wr) begin
            wr_n <= wr_n + 1;
            if (bus_addr[15]) begin
                dev_log[log_n[5:0]] <= bus_wdata;
                log_n <= log_n + 1;
            end else begin
                mem[bus_addr[7:0]] <= bus_wdata;
            end
        end
    end

    csdma_ctrl #(.AW(AW), .DW(DW), .CW(16)) u_csdma_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bus_req   (bus_req),
        .bus_grant (bus_grant),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] sel, output logic [DW-1:0] d);
        cfg_sel = sel;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
    endtask

    task automatic program_block(input logic [DW-1:0] dev, input logic [DW-1:0] ma,
                                 input logic [DW-1:0] cnt, input logic dir);
        reg_wr(3'd1, dev);
        reg_wr(3'd2, ma);
        reg_wr(3'd3, cnt);
        reg_wr(3'd0, {14'd0, 1'b1, dir});
    endtask

    task automatic clear_done();
        reg_wr(3'd4, 16'h0002);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        reg_rd(3'd4, v);
        check(v == 16'h0, "R1", "status after reset", v, 0);
        check(irq == 1'b0 && bus_req == 1'b0, "R1", "irq/req after reset", {irq, bus_req}, 0);
        check(bus_rd == 1'b0 && bus_wr == 1'b0, "R1", "strobes after reset", {bus_rd, bus_wr}, 0);
    endtask

    task automatic t_dev_to_mem();
        logic [DW-1:0] v;
        int r0, w0, d0;
        r0 = rd_n; w0 = wr_n; d0 = dev_rd_n;
        program_block(16'h8000, 16'h0010, 16'd4, 1'b1);
        wait_irq();
        check(irq == 1'b1, "R7", "irq after 4-word block", irq, 1);
        for (int k = 0; k < 4; k++)
            check(mem[8'h10 + k] == dev_base + DW'(d0 + k), "R3", "dev->mem word",
                  mem[8'h10 + k], dev_base + DW'(d0 + k));
        check(rd_n - r0 == 4 && wr_n - w0 == 4, "R3", "bus cycles (reads*256+writes)",
              (rd_n - r0) * 256 + (wr_n - w0), 4 * 256 + 4);
        check(dev_rd_n - d0 == 4, "R3", "reads at peripheral", dev_rd_n - d0, 4);
        reg_rd(3'd2, v);
        check(v == 16'h0014, "R4", "memory address after block", v, 16'h14);
        reg_rd(3'd3, v);
        check(v == 16'h0, "R4", "count after block", v, 0);
        reg_rd(3'd1, v);
        check(v == 16'h8000, "R4", "peripheral address constant", v, 16'h8000);
        reg_rd(3'd4, v);
        check(v == 16'h2, "R7", "status done, not busy", v, 2);
        check(rel_bad == 0, "R5", "request held after write", rel_bad, 0);
    endtask

    task automatic t_mem_to_dev();
        int l0, d0;
        logic [DW-1:0] v;
        clear_done();
        l0 = log_n; d0 = dev_rd_n;
        program_block(16'h8004, 16'h0010, 16'd3, 1'b0);
        wait_irq();
        check(log_n - l0 == 3, "R3", "writes at peripheral", log_n - l0, 3);
        check(dev_rd_n == d0, "R3", "no peripheral reads", dev_rd_n - d0, 0);
        for (int k = 0; k < 3; k++)
            check(dev_log[l0 + k] == mem[8'h10 + k], "R3", "mem->dev word",
                  dev_log[l0 + k], mem[8'h10 + k]);
        reg_rd(3'd2, v);
        check(v == 16'h0013, "R4", "memory address after 3 words", v, 16'h13);
        check(rel_bad == 0, "R5", "request released between words", rel_bad, 0);
    endtask

    task automatic t_irq_hold();
        logic [DW-1:0] v;
        repeat (20) @(negedge clk);
        check(irq == 1'b1, "R7", "irq held while idle", irq, 1);
        clear_done();
        check(irq == 1'b0, "R7", "irq after clear", irq, 0);
        reg_rd(3'd4, v);
        check(v == 16'h0, "R7", "status after clear", v, 0);
    endtask

    task automatic t_zero_count();
        int r0, w0;
        r0 = rd_n; w0 = wr_n;
        reg_wr(3'd3, 16'd0);
        reg_wr(3'd0, 16'h0003);
        check(irq == 1'b1, "R8", "irq one edge after zero start", irq, 1);
        repeat (5) @(negedge clk);
        check(rd_n == r0 && wr_n == w0, "R8", "bus cycles for zero count",
              (rd_n - r0) + (wr_n - w0), 0);
        check(bus_req == 1'b0, "R8", "no request for zero count", bus_req, 0);
        clear_done();
    endtask

    task automatic t_grant_wait();
        int r0, w0;
        r0 = rd_n; w0 = wr_n;
        cpu_hold = 1'b1;
        program_block(16'h8000, 16'h0020, 16'd1, 1'b1);
        repeat (10) @(negedge clk);
        check(bus_req == 1'b1, "R6", "request held without grant", bus_req, 1);
        check(rd_n == r0 && wr_n == w0, "R6", "no strobe without grant",
              (rd_n - r0) + (wr_n - w0), 0);
        cpu_hold = 1'b0;
        wait_irq();
        check(rd_n - r0 == 1 && wr_n - w0 == 1, "R6", "word moved after grant",
              (rd_n - r0) + (wr_n - w0), 2);
        clear_done();
    endtask

    task automatic t_busy_ignore();
        logic [DW-1:0] v;
        int d0, l0, w0;
        d0 = dev_rd_n; l0 = log_n; w0 = wr_n;
        cpu_hold = 1'b1;
        program_block(16'h8000, 16'h0060, 16'd2, 1'b1);
        reg_wr(3'd2, 16'h0070);
        reg_wr(3'd3, 16'd7);
        reg_wr(3'd1, 16'h8008);
        reg_wr(3'd0, 16'h0002);
        reg_rd(3'd3, v);
        check(v == 16'd2, "R9", "count write while busy", v, 2);
        reg_rd(3'd2, v);
        check(v == 16'h0060, "R9", "memory address write while busy", v, 16'h60);
        reg_rd(3'd1, v);
        check(v == 16'h8000, "R9", "peripheral address write while busy", v, 16'h8000);
        reg_rd(3'd0, v);
        check(v == 16'h0001, "R10", "direction after start while busy", v, 1);
        reg_rd(3'd4, v);
        check(v == 16'h0001, "R10", "still busy", v, 1);
        cpu_hold = 1'b0;
        wait_irq();
        check(dev_rd_n - d0 == 2 && log_n == l0, "R10", "block kept dev->mem direction",
              (dev_rd_n - d0) * 256 + (log_n - l0), 2 * 256);
        check(wr_n - w0 == 2, "R9", "only programmed count moved", wr_n - w0, 2);
        check(mem[8'h61] == dev_base + DW'(d0 + 1), "R9", "second word at 0x61",
              mem[8'h61], dev_base + DW'(d0 + 1));
        reg_rd(3'd2, v);
        check(v == 16'h0062, "R9", "memory address after block", v, 16'h62);
        clear_done();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dev_to_mem();
        t_irq_hold();
        t_mem_to_dev();
        clear_done();
        t_zero_count();
        t_grant_wait();
        t_busy_ignore();
        check(rel_bad == 0, "R5", "request release over whole run", rel_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule